// File: doc/BRIEF.md
# Alarm-Launched Periodic Pulse Generator

This block watches a free-running 64-bit nanosecond time value and compares it against two alarm registers. When the time reaches an armed alarm, the block raises a one-cycle event strobe and latches an alarm level, shown on a pin whose polarity is set by a control bit. The first alarm has a second job: it launches up to three periodic pulse channels. Each channel then emits a single-cycle pulse every time its accumulated time reaches its programmed period.

Software uses it to line pulse trains up with an absolute time. A typical case is a once-per-second pulse on the second boundary. Software sets alarm 1 one clock step before that boundary and sets the start control bit. Each later write of alarm 1 can realign the trains, unless a control bit turns realignment off. The time source, the per-cycle time step and the control word all come in as inputs. The event vector keeps fixed bit positions, because an event/mask register downstream decodes them.

Top module: `alarm_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pulse_out` and `evt_out` are zero. `alm_out[0]` equals `ctrl[31]` and `alm_out[1]` equals `ctrl[30]`, because both alarm levels are inactive and both alarms are disarmed.
- R2: An alarm fires once. Alarm k is armed and `cur_time >= value`, with no write to alarm k in that cycle. At the next clock edge, `evt_out[16]` (alarm 1) or `evt_out[17]` (alarm 2) goes high for exactly one cycle, and the alarm disarms.
- R3: A write with `alm_wr_hi`=0 stores the low 32 bits as pending and disarms that alarm. A write with `alm_wr_hi`=1 commits {data, pending low} and arms it. A low-half write alone can never cause an event.
- R4: The alarm level sets on the edge where that alarm fires and clears on any write to that alarm. `alm_out[0]` = level1 XOR `ctrl[31]` and `alm_out[1]` = level2 XOR `ctrl[30]`.
- R5: A pulse channel starts running only when alarm 1 fires while `ctrl[28]` (start) is 1. Setting start alone produces no pulses.
- R6: A running channel adds `tick_ns` to its accumulator on each edge. When the sum reaches `period`, the channel emits a one-cycle pulse on `pulse_out[c]` and on `evt_out[7-c]`, and keeps the remainder. For a period of k·tick, the first pulse appears k edges after the launching alarm edge. The design assumes `tick_ns` ≤ period.
- R7: With `ctrl[14]`=0, an alarm 1 fire on a running channel resets its accumulator to zero, and the channel emits no pulse on that edge. With `ctrl[14]`=1, a running channel ignores alarm 1 and keeps its phase.
- R8: While `ctrl[28]` is 0, every channel stops, clears its accumulator and emits nothing. Channels need a new alarm 1 fire to restart.
- R9: A channel whose period is zero emits no pulses.
- R10: Bits of `evt_out` other than 17, 16, 7, 6 and 5 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 64 | Running time in nanoseconds |
| ctrl | input | 32 | Control word: 31/30 alarm polarity, 28 start, 14 realign disable |
| tick_ns | input | 10 | Time added per clock cycle, in nanoseconds |
| period_ns | input | 96 | Three 32-bit periods in nanoseconds, channel c at bits [32c+31:32c] |
| alm_wr_en | input | 1 | Alarm half write strobe |
| alm_wr_sel | input | 1 | Alarm select: 0 alarm 1, 1 alarm 2 |
| alm_wr_hi | input | 1 | 1 writes the high half and arms, 0 writes the low half |
| alm_wr_data | input | 32 | Alarm half write data |
| alm_out | output | 2 | Alarm levels after polarity |
| pulse_out | output | 3 | Periodic pulse outputs |
| evt_out | output | 32 | One-cycle event strobes |

## Verification
A wrong armed flag shows up either as a missing alarm strobe or as a second strobe one cycle after the first. Either is visible within a cycle of the time passing the alarm value. A corrupted accumulator or running flag shifts the phase of the next pulse. That error surfaces at most one period later, as a pulse on the wrong edge relative to the alarm strobe. A stuck level or a polarity mix-up is visible on `alm_out` in the same cycle as the alarm event.

// File: rtl/alarm_pulse_gen_pkg.sv
// Shared constants for the alarm-launched pulse generator.
// Bit positions are fixed because a downstream event/mask register decodes them.
package alarm_pulse_gen_pkg;
    localparam int EVB_ALARM1   = 16;   // alarm 1 event bit
    localparam int EVB_ALARM2   = 17;   // alarm 2 event bit
    localparam int EVB_PULSE0   = 7;    // channel c uses bit EVB_PULSE0 - c
    localparam int CTB_POL1     = 31;   // alarm 1 output polarity
    localparam int CTB_POL2     = 30;   // alarm 2 output polarity
    localparam int CTB_START    = 28;   // pulse launch enable
    localparam int CTB_NOALIGN  = 14;   // realignment disable
endpackage

// File: rtl/apg_alarm.sv
// One alarm comparator.
// Holds a pending low half and a committed full value. It arms only on a
// high-half write and fires once when cur_time reaches the committed value.
// Assumes: writes are one half per cycle; a write in a cycle overrides a fire.
module apg_alarm #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [TIME_W/2-1:0] wr_data,
    output logic              hit_o,
    output logic              evt_o,
    output logic              level_o
);
    localparam int HALF_W = TIME_W / 2;

    logic [HALF_W-1:0] pend_lo_q;
    logic [TIME_W-1:0] value_q;
    logic              armed_q;
    logic              evt_q;
    logic              level_q;

    // Fire condition for this edge; a write suppresses it.
    assign hit_o = armed_q && !wr_en && (cur_time >= value_q);

    // Alarm register, arming state, event strobe and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_lo_q <= '0;
            value_q   <= '0;
            armed_q   <= 1'b0;
            evt_q     <= 1'b0;
            level_q   <= 1'b0;
        end else begin
            evt_q <= hit_o;
            if (wr_en) begin
                armed_q <= wr_hi;
                level_q <= 1'b0;
                if (wr_hi) value_q   <= {wr_data, pend_lo_q};
                else       pend_lo_q <= wr_data;
            end else if (hit_o) begin
                armed_q <= 1'b0;
                level_q <= 1'b1;
            end
        end
    end

    assign evt_o   = evt_q;
    assign level_o = level_q;
endmodule

// File: rtl/apg_pulse_chan.sv
// One periodic pulse channel.
// Launched by an alarm-1 fire while start is set. It accumulates tick per
// cycle and pulses for one cycle whenever the sum reaches the period.
// Assumes: tick <= period whenever period is non-zero.
module apg_pulse_chan #(
    parameter int PER_W  = 32,
    parameter int TICK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              realign_dis,
    input  logic              launch,
    input  logic [PER_W-1:0]  period,
    input  logic [TICK_W-1:0] tick,
    output logic              pulse_o
);
    logic             running_q;
    logic [PER_W-1:0] acc_q;
    logic             pulse_q;
    logic [PER_W:0]   sum;
    logic [PER_W:0]   rem;

    // Next accumulated time and the remainder after one period.
    assign sum = {1'b0, acc_q} + (PER_W+1)'(tick);
    assign rem = sum - {1'b0, period};

    // Launch, realign, stop and period counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            acc_q     <= '0;
            pulse_q   <= 1'b0;
        end else if (!start) begin
            running_q <= 1'b0;
            acc_q     <= '0;
            pulse_q   <= 1'b0;
        end else if (launch && (!running_q || !realign_dis)) begin
            running_q <= 1'b1;
            acc_q     <= '0;
            pulse_q   <= 1'b0;
        end else if (running_q && (period != '0)) begin
            if (sum >= {1'b0, period}) begin
                pulse_q <= 1'b1;
                acc_q   <= rem[PER_W-1:0];
            end else begin
                pulse_q <= 1'b0;
                acc_q   <= sum[PER_W-1:0];
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/alarm_pulse_gen.sv
// Top: two alarms and N_PULSE periodic pulse channels launched by alarm 1.
// Assumes: N_PULSE <= 3, so that event bits 7..5 cover the channels.
module alarm_pulse_gen
    import alarm_pulse_gen_pkg::*;
#(
    parameter int TIME_W  = 64,
    parameter int PER_W   = 32,
    parameter int TICK_W  = 10,
    parameter int N_PULSE = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TIME_W-1:0]        cur_time,
    input  logic [31:0]              ctrl,
    input  logic [TICK_W-1:0]        tick_ns,
    input  logic [N_PULSE*PER_W-1:0] period_ns,
    input  logic                     alm_wr_en,
    input  logic                     alm_wr_sel,
    input  logic                     alm_wr_hi,
    input  logic [TIME_W/2-1:0]      alm_wr_data,
    output logic [1:0]               alm_out,
    output logic [N_PULSE-1:0]       pulse_out,
    output logic [31:0]              evt_out
);
    localparam int N_ALARM = 2;

    logic [N_ALARM-1:0] hit;
    logic [N_ALARM-1:0] alm_evt;
    logic [N_ALARM-1:0] alm_lvl;
    logic [N_PULSE-1:0] pulse;

    // One comparator per alarm; the write select routes the strobe.
    for (genvar a = 0; a < N_ALARM; a++) begin : g_alarm
        apg_alarm #(.TIME_W(TIME_W)) alarm_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur_time(cur_time),
            .wr_en   (alm_wr_en && (alm_wr_sel == 1'(a))),
            .wr_hi   (alm_wr_hi),
            .wr_data (alm_wr_data),
            .hit_o   (hit[a]),
            .evt_o   (alm_evt[a]),
            .level_o (alm_lvl[a])
        );
    end

    // One channel per pulse output, all launched by alarm 1.
    for (genvar c = 0; c < N_PULSE; c++) begin : g_chan
        apg_pulse_chan #(.PER_W(PER_W), .TICK_W(TICK_W)) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (ctrl[CTB_START]),
            .realign_dis(ctrl[CTB_NOALIGN]),
            .launch     (hit[0]),
            .period     (period_ns[c*PER_W +: PER_W]),
            .tick       (tick_ns),
            .pulse_o    (pulse[c])
        );
    end

    // Alarm pins with programmable polarity.
    assign alm_out[0] = alm_lvl[0] ^ ctrl[CTB_POL1];
    assign alm_out[1] = alm_lvl[1] ^ ctrl[CTB_POL2];
    assign pulse_out  = pulse;

    // Event vector assembly at the fixed bit positions.
    always_comb begin
        evt_out             = '0;
        evt_out[EVB_ALARM1] = alm_evt[0];
        evt_out[EVB_ALARM2] = alm_evt[1];
        for (int c = 0; c < N_PULSE; c++) evt_out[EVB_PULSE0 - c] = pulse[c];
    end
endmodule

// File: rtl/alarm_pulse_gen_chk.sv
// Property checker for alarm_pulse_gen, attached by bind.
module alarm_pulse_gen_chk #(
    parameter int N_PULSE = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        ctrl,
    input logic               alm_wr_en,
    input logic               alm_wr_sel,
    input logic               alm_wr_hi,
    input logic [1:0]         alm_out,
    input logic [N_PULSE-1:0] pulse_out,
    input logic [31:0]        evt_out
);
    // R2: an alarm strobe never lasts two cycles.
    p_alarm_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out[16] |=> !evt_out[16]);

    // R3: a low-half write to alarm 1 cannot be followed by its event.
    p_lo_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_wr_en && !alm_wr_hi && !alm_wr_sel) |=> !evt_out[16]);

    // R4: when alarm 2 fires, its pin shows the active level.
    p_level_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out[17] |-> (alm_out[1] != ctrl[30]));

    // R5: a pulse requires start to have been set on the producing edge.
    p_pulse_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_out) |-> $past(ctrl[28]));

    // R7: a realigning alarm 1 fire leaves no pulse on that edge.
    p_realign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_out[16] && !$past(ctrl[14])) |-> (pulse_out == '0));

    // R8: start cleared means silence after the next edge.
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[28] |=> (pulse_out == '0));

    // R10: reserved event bits stay zero.
    p_evt_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_out & ~32'h0003_00E0) == 32'h0);
endmodule

bind alarm_pulse_gen alarm_pulse_gen_chk #(.N_PULSE(N_PULSE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .alm_wr_en (alm_wr_en),
    .alm_wr_sel(alm_wr_sel),
    .alm_wr_hi (alm_wr_hi),
    .alm_out   (alm_out),
    .pulse_out (pulse_out),
    .evt_out   (evt_out)
);

// File: tb/alarm_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module alarm_pulse_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cur_time = 64'h0000_0001_FFFF_F000;
    logic [31:0] ctrl = '0;
    logic [9:0]  tick_ns = 10'd4;
    logic [95:0] period_ns = '0;
    logic        alm_wr_en = 1'b0, alm_wr_sel = 1'b0, alm_wr_hi = 1'b0;
    logic [31:0] alm_wr_data = '0;
    logic [1:0]  alm_out;
    logic [2:0]  pulse_out;
    logic [31:0] evt_out;

    int checks = 0, errors = 0;
    bit chk_en = 0, time_run = 0;
    int cyc = 0, cnt16 = 0, cnt17 = 0;
    int cntp [3] = '{0, 0, 0};
    int last_m16 = 0, last_p0 = 0;

    // reference model state
    logic [31:0] m_lo [2];
    logic [63:0] m_val [2];
    bit m_arm [2], m_lvl [2], m_evt [2];
    bit m_run [3], m_pls [3];
    logic [32:0] m_acc [3];

    alarm_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .ctrl(ctrl),
        .tick_ns(tick_ns), .period_ns(period_ns), .alm_wr_en(alm_wr_en),
        .alm_wr_sel(alm_wr_sel), .alm_wr_hi(alm_wr_hi), .alm_wr_data(alm_wr_data),
        .alm_out(alm_out), .pulse_out(pulse_out), .evt_out(evt_out)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (time_run) cur_time <= cur_time + 64'(tick_ns);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Model the required behaviour at each edge, from the requirements.
    task automatic model_step();
        bit hit [2];
        logic [32:0] s, p;
        if (!rst_n) begin
            for (int a = 0; a < 2; a++) begin
                m_lo[a] = '0; m_val[a] = '0; m_arm[a] = 0; m_lvl[a] = 0; m_evt[a] = 0;
            end
            for (int c = 0; c < 3; c++) begin
                m_run[c] = 0; m_pls[c] = 0; m_acc[c] = '0;
            end
            return;
        end
        for (int a = 0; a < 2; a++) begin
            bit w;
            w = alm_wr_en && (alm_wr_sel == 1'(a));
            hit[a] = m_arm[a] && !w && (cur_time >= m_val[a]);
            m_evt[a] = hit[a];
            if (w) begin
                m_lvl[a] = 0;
                m_arm[a] = alm_wr_hi;
                if (alm_wr_hi) m_val[a] = {alm_wr_data, m_lo[a]};
                else m_lo[a] = alm_wr_data;
            end else if (hit[a]) begin
                m_arm[a] = 0; m_lvl[a] = 1;
            end
        end
        for (int c = 0; c < 3; c++) begin
            p = {1'b0, period_ns[c*32 +: 32]};
            if (!ctrl[28]) begin
                m_run[c] = 0; m_acc[c] = '0; m_pls[c] = 0;
            end else if (hit[0] && (!m_run[c] || !ctrl[14])) begin
                m_run[c] = 1; m_acc[c] = '0; m_pls[c] = 0;
            end else if (m_run[c] && p != 0) begin
                s = m_acc[c] + 33'(tick_ns);
                if (s >= p) begin m_pls[c] = 1; m_acc[c] = s - p; end
                else begin m_pls[c] = 0; m_acc[c] = s; end
            end else m_pls[c] = 0;
        end
    endtask

    // Step the model at the edge; compare and monitor 1 ns later.
    always @(posedge clk) begin
        logic [31:0] ev;
        model_step();
        #1;
        cyc++;
        if (evt_out[16]) begin cnt16++; last_m16 = cyc; end
        if (evt_out[17]) cnt17++;
        for (int c = 0; c < 3; c++) if (pulse_out[c]) cntp[c]++;
        if (pulse_out[0]) last_p0 = cyc;
        if (chk_en) begin
            ev = '0;
            ev[16] = m_evt[0]; ev[17] = m_evt[1];
            for (int c = 0; c < 3; c++) ev[7-c] = m_pls[c];
            chk("R4", "alm_out", 64'(alm_out),
                64'({m_lvl[1] ^ ctrl[30], m_lvl[0] ^ ctrl[31]}));
            chk("R6", "pulse_out", 64'(pulse_out), 64'({m_pls[2], m_pls[1], m_pls[0]}));
            chk("R2", "evt_alarm", 64'(evt_out[17:16]), 64'(ev[17:16]));
            chk("R10", "evt_reserved", 64'(evt_out & ~32'h0003_00E0), 64'h0);
            chk("R6", "evt_pulse", 64'(evt_out[7:5]), 64'(ev[7:5]));
        end
    end

    task automatic wr_alarm(input bit sel, input logic [63:0] v, input bit both);
        @(negedge clk);
        alm_wr_en = 1; alm_wr_sel = sel; alm_wr_hi = 0; alm_wr_data = v[31:0];
        if (both) begin
            @(negedge clk);
            alm_wr_hi = 1; alm_wr_data = v[63:32];
        end
        @(negedge clk);
        alm_wr_en = 0; alm_wr_hi = 0;
    endtask

    task automatic clr_counts();
        cnt16 = 0; cnt17 = 0;
        for (int c = 0; c < 3; c++) cntp[c] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        ctrl = 32'hC000_0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "pulse_out", 64'(pulse_out), 64'h0);
        chk("R1", "evt_out", 64'(evt_out), 64'h0);
        chk("R1", "alm_out", 64'(alm_out), 64'h3);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "alm_out after release", 64'(alm_out), 64'h3);
        chk("R1", "evt_out after release", 64'(evt_out), 64'h0);
        ctrl = 32'h0;
        chk_en = 1; time_run = 1;

        // R2, R6, R9: launch with periods 20, 12, 0 at tick 4
        period_ns = {32'd0, 32'd12, 32'd20};
        ctrl[28] = 1;
        clr_counts();
        wr_alarm(0, cur_time + 64'd40, 1);
        repeat (60) @(negedge clk);
        chk("R2", "alarm1 fires once", 64'(cnt16), 64'd1);
        chk("R9", "zero-period channel pulses", 64'(cntp[2]), 64'd0);
        chk("R6", "channel 0 pulse phase", 64'((last_p0 - last_m16) % 5), 64'd0);

        // R3: low half alone never fires, commit then fires
        clr_counts();
        wr_alarm(1, 64'h0, 0);
        repeat (20) @(negedge clk);
        chk("R3", "low-only write events", 64'(cnt17), 64'd0);
        wr_alarm(1, 64'h0, 0);
        @(negedge clk); alm_wr_en = 1; alm_wr_sel = 1; alm_wr_hi = 1; alm_wr_data = '0;
        @(negedge clk); alm_wr_en = 0; alm_wr_hi = 0;
        repeat (5) @(negedge clk);
        chk("R3", "commit then fire", 64'(cnt17), 64'd1);
        ctrl[30] = 1;
        @(negedge clk);
        chk("R4", "alarm2 level inverted", 64'(alm_out[1]), 64'd0);

        // R7: realign on a running train, then with realign disabled
        wr_alarm(0, cur_time + 64'd26, 1);
        repeat (30) @(negedge clk);
        chk("R7", "realigned phase", 64'((last_p0 - last_m16) % 5), 64'd0);
        ctrl[14] = 1;
        wr_alarm(0, cur_time + 64'd30, 1);
        repeat (30) @(negedge clk);
        ctrl[14] = 0;

        // R8: stop clears trains
        ctrl[28] = 0;
        @(negedge clk);
        clr_counts();
        repeat (40) @(negedge clk);
        chk("R8", "stopped pulses", 64'(cntp[0] + cntp[1]), 64'd0);

        // R5: start without a new alarm 1 fire gives nothing
        ctrl[28] = 1;
        clr_counts();
        repeat (40) @(negedge clk);
        chk("R5", "start without launch", 64'(cntp[0] + cntp[1]), 64'd0);

        // Random phase: tick 8, periods 40, 56, 24
        tick_ns = 10'd8;
        period_ns = {32'd24, 32'd56, 32'd40};
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 4)      wr_alarm(r[0], cur_time + 64'(8 * ($urandom % 40)), 1);
            else if (r == 4) wr_alarm(r[0], cur_time + 64'(8 * ($urandom % 40)), 0);
            else if (r == 5) ctrl[28] = ~ctrl[28];
            else if (r == 6) ctrl[14] = ~ctrl[14];
            else if (r == 7) ctrl[31:30] = 2'($urandom);
            repeat (1 + ($urandom % 8)) @(negedge clk);
        end
        chk("R6", "random phase saw pulses", 64'(cntp[0] > 0), 64'd1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule